// File: doc/BRIEF.md
# Receive FIFO Watermark DMA Requester

This block decides when an incoming receive frame has collected enough bytes in the receive FIFO for a DMA transfer to memory to be worth starting. It counts the byte write strobes of the current frame and compares the count with a threshold. The threshold comes from a 2-bit watermark field. It is then adjusted for the duplex mode and for whether short (runt) frames are accepted. When the threshold is crossed, or when a complete valid frame is reported, the block raises a DMA request. The request stays high until the FIFO has drained after the frame ends.

In half duplex, with runt acceptance off, the request is held back until 64 bytes of the frame are present. This covers the collision window, so that frames which are cut short by a collision never start a transfer. A watermark above 64 still applies in this mode. In full duplex, or with runt acceptance on, the programmed watermark is used as it stands. The watermark field can only be written while the stop or suspend control bit is set. A read view shows the field with two reserved bits that are always one.

Top module: `rx_wmark_dma_req`

## Requirements
- R1: After asynchronous reset, dmaReq is 0 and cfgRdNibble reads 4'b1101 (bits 3:2 fixed at 1, bits 1:0 the watermark field, reset value 2'b01).
- R2: A pulse on cfgWrEn loads cfgWrData into the watermark field only while stopBit or suspendBit is 1. Otherwise the field keeps its value.
- R3: A synchronous swReset pulse returns the watermark field to 2'b01 and drops dmaReq. Holding stopBit high on its own leaves the field unchanged.
- R4: With fullDuplex=1, the watermark codes 00, 01, 10 and 11 give thresholds of 16, 64, 128 and 128 bytes. dmaReq rises one cycle after the clock edge that counts the byte which reaches the threshold.
- R5: With fullDuplex=0 and runtAccept=0, the threshold is the larger of the watermark threshold and 64 bytes.
- R6: With fullDuplex=0 and runtAccept=1, the plain watermark threshold of R4 applies.
- R7: A frameEnd pulse with frameValid=1 raises dmaReq in the next cycle, whatever the byte count.
- R8: A frameEnd pulse with frameValid=0 that comes before the threshold is reached raises no request.
- R9: frameAbort clears the byte count, drops any request and returns the block to idle. The next frame counts from zero.
- R10: Once raised, dmaReq stays high until fifoEmpty is seen after the frame end. fifoEmpty before the frame end has no effect.
- R11: The byte counter saturates at its maximum value instead of wrapping, so a long frame keeps its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| swReset | input | 1 | Synchronous software reset pulse |
| cfgWrEn | input | 1 | Watermark field write strobe |
| cfgWrData | input | 2 | Watermark code to write |
| stopBit | input | 1 | Stop control bit; enables watermark writes |
| suspendBit | input | 1 | Suspend control bit; enables watermark writes |
| cfgRdNibble | output | 4 | Read view: {2'b11, watermark field} |
| fullDuplex | input | 1 | 1 = full-duplex link |
| runtAccept | input | 1 | 1 = short frames are accepted |
| byteWr | input | 1 | One byte written into the receive FIFO |
| frameStart | input | 1 | First-byte marker pulse of a new frame |
| frameEnd | input | 1 | Frame complete pulse |
| frameValid | input | 1 | Qualifies frameEnd: frame is valid |
| frameAbort | input | 1 | Frame discarded pulse |
| fifoEmpty | input | 1 | Receive FIFO is empty |
| dmaReq | output | 1 | Receive DMA request |

## Verification
The assertions assume well-ordered frame framing. Each frame begins with one frameStart pulse and ends with exactly one frameEnd or frameAbort pulse. No new frameStart arrives while a request is still draining, and byteWr is high only between frame start and frame end. The stimulus tasks produce exactly this order. They send each frame as a start pulse, a burst of byte strobes, one end or abort pulse, and a fifoEmpty pulse before the next frame begins. Watermark writes happen only between frames.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RECV  = 2'd1,
    ST_REQ   = 2'd2,
    ST_DRAIN = 2'd3
  } rxState_e;

  typedef struct packed {
    logic clrCnt;
    logic cntEn;
  } cntStrobe_t;
endpackage

// File: rtl/rxw_datapath.sv
module rxw_datapath
  import rxw_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int SLOT_BYTES = 64,
  parameter int WM_LOW     = 16,
  parameter int WM_MID     = 64,
  parameter int WM_HIGH    = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             swReset,
  input  cntStrobe_t       strobe,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgWrData,
  input  logic             stopBit,
  input  logic             suspendBit,
  input  logic             fullDuplex,
  input  logic             runtAccept,
  output logic             thrMet,
  output logic [3:0]       cfgRdNibble
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] THR_LOW = CNT_W'(WM_LOW);
  localparam logic [CNT_W-1:0] THR_MID = CNT_W'(WM_MID);
  localparam logic [CNT_W-1:0] THR_HIGH = CNT_W'(WM_HIGH);
  localparam logic [CNT_W-1:0] THR_SLOT = CNT_W'(SLOT_BYTES);
  localparam logic [1:0] WM_RESET = 2'b01;

  logic [1:0]       wmField;
  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W-1:0] wmBytes;
  logic [CNT_W-1:0] effThr;
  logic             cfgOpen;

  assign cfgOpen = stopBit | suspendBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  wmField <= WM_RESET;
    else if (swReset)           wmField <= WM_RESET;
    else if (cfgWrEn && cfgOpen) wmField <= cfgWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              byteCnt <= '0;
    else if (swReset || strobe.clrCnt)      byteCnt <= '0;
    else if (strobe.cntEn && byteCnt != CNT_MAX) byteCnt <= byteCnt + 1'b1;
  end

  always_comb begin
    unique case (wmField)
      2'b00:   wmBytes = THR_LOW;
      2'b01:   wmBytes = THR_MID;
      default: wmBytes = THR_HIGH;
    endcase
    effThr = wmBytes;
    if (!fullDuplex && !runtAccept && wmBytes < THR_SLOT) effThr = THR_SLOT;
  end

  assign thrMet      = byteCnt >= effThr;
  assign cfgRdNibble = {2'b11, wmField};

  // R2: writes outside stop/suspend leave the field alone
  p_wm_locked_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !cfgOpen && !swReset) |=> $stable(wmField));
  // R3: software reset restores the default code
  p_wm_soft_reset_r3: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> (wmField == WM_RESET));
  // R11: counter holds at its maximum
  p_cnt_saturate_r11: assert property (@(posedge clk) disable iff (!rstN)
    (byteCnt == CNT_MAX && strobe.cntEn && !strobe.clrCnt && !swReset) |=> (byteCnt == CNT_MAX));
  // R5: half duplex without runt acceptance never qualifies below the slot
  p_slot_guard_r5: assert property (@(posedge clk) disable iff (!rstN)
    (thrMet && !fullDuplex && !runtAccept) |-> (byteCnt >= THR_SLOT));
  // R9: a clear strobe empties the counter
  p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrCnt |=> (byteCnt == '0));
endmodule

// File: rtl/rxw_control.sv
module rxw_control
  import rxw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       swReset,
  input  logic       byteWr,
  input  logic       frameStart,
  input  logic       frameEnd,
  input  logic       frameValid,
  input  logic       frameAbort,
  input  logic       fifoEmpty,
  input  logic       thrMet,
  output cntStrobe_t strobe,
  output logic       dmaReq
);
  rxState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (frameStart) stateNext = ST_RECV;
      ST_RECV: begin
        if (frameAbort)      stateNext = ST_IDLE;
        else if (frameStart) stateNext = ST_RECV;
        else if (frameEnd)   stateNext = (frameValid || thrMet) ? ST_DRAIN : ST_IDLE;
        else if (thrMet)     stateNext = ST_REQ;
      end
      ST_REQ: begin
        if (frameAbort)    stateNext = ST_IDLE;
        else if (frameEnd) stateNext = ST_DRAIN;
      end
      ST_DRAIN: if (fifoEmpty) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        state <= ST_IDLE;
    else if (swReset) state <= ST_IDLE;
    else              state <= stateNext;
  end

  always_comb begin
    strobe.clrCnt = frameStart | frameAbort;
    strobe.cntEn  = byteWr && (state == ST_RECV || state == ST_REQ);
  end

  assign dmaReq = (state == ST_REQ) || (state == ST_DRAIN);

  // R7/R4/R5: a request only starts from a met threshold or a frame end
  p_req_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaReq) |-> ($past(thrMet) || $past(frameEnd)));
  // R10: the request only falls on empty FIFO, abort or software reset
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dmaReq) |-> ($past(fifoEmpty) || $past(frameAbort) || $past(swReset)));
  // R9: abort during reception leaves no request
  p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (frameAbort && state != ST_DRAIN) |=> !dmaReq);
  // R8: invalid end below threshold gives no request
  p_bad_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECV && frameEnd && !frameValid && !thrMet && !frameAbort && !frameStart && !swReset) |=> !dmaReq);
endmodule

// File: rtl/rx_wmark_dma_req.sv
module rx_wmark_dma_req
  import rxw_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int SLOT_BYTES = 64,
  parameter int WM_LOW     = 16,
  parameter int WM_MID     = 64,
  parameter int WM_HIGH    = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       swReset,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgWrData,
  input  logic       stopBit,
  input  logic       suspendBit,
  output logic [3:0] cfgRdNibble,
  input  logic       fullDuplex,
  input  logic       runtAccept,
  input  logic       byteWr,
  input  logic       frameStart,
  input  logic       frameEnd,
  input  logic       frameValid,
  input  logic       frameAbort,
  input  logic       fifoEmpty,
  output logic       dmaReq
);
  cntStrobe_t strobe;
  logic       thrMet;

  rxw_control u_ctl (
    .clk(clk), .rstN(rstN), .swReset(swReset), .byteWr(byteWr),
    .frameStart(frameStart), .frameEnd(frameEnd), .frameValid(frameValid),
    .frameAbort(frameAbort), .fifoEmpty(fifoEmpty), .thrMet(thrMet),
    .strobe(strobe), .dmaReq(dmaReq)
  );

  rxw_datapath #(
    .CNT_W(CNT_W), .SLOT_BYTES(SLOT_BYTES),
    .WM_LOW(WM_LOW), .WM_MID(WM_MID), .WM_HIGH(WM_HIGH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .swReset(swReset), .strobe(strobe),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .stopBit(stopBit),
    .suspendBit(suspendBit), .fullDuplex(fullDuplex), .runtAccept(runtAccept),
    .thrMet(thrMet), .cfgRdNibble(cfgRdNibble)
  );
endmodule

// File: tb/test_rx_wmark_dma_req.sv
module test_rx_wmark_dma_req;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swReset = 0, cfgWrEn = 0, stopBit = 0, suspendBit = 0;
  logic [1:0] cfgWrData = 2'b00;
  logic fullDuplex = 0, runtAccept = 0, byteWr = 0, frameStart = 0;
  logic frameEnd = 0, frameValid = 0, frameAbort = 0, fifoEmpty = 0;
  logic [3:0] cfgRdNibble;
  logic dmaReq;
  int total = 0, bad = 0, cycles = 0;

  always #5 clk = ~clk;

  rx_wmark_dma_req i_rx_wmark_dma_req (
    .clk(clk), .rstN(rstN), .swReset(swReset), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .stopBit(stopBit), .suspendBit(suspendBit),
    .cfgRdNibble(cfgRdNibble), .fullDuplex(fullDuplex), .runtAccept(runtAccept),
    .byteWr(byteWr), .frameStart(frameStart), .frameEnd(frameEnd),
    .frameValid(frameValid), .frameAbort(frameAbort), .fifoEmpty(fifoEmpty),
    .dmaReq(dmaReq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s dmaReq actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chkNib(string req, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cfgRdNibble actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic writeWm(logic [1:0] v, logic st, logic su);
    stopBit = st; suspendBit = su; cfgWrData = v; cfgWrEn = 1'b1;
    tick();
    cfgWrEn = 1'b0; stopBit = 1'b0; suspendBit = 1'b0;
  endtask

  task automatic startFrame();
    frameStart = 1'b1; tick(); frameStart = 1'b0;
  endtask

  task automatic sendBytes(int n);
    if (n > 0) begin
      byteWr = 1'b1;
      repeat (n) tick();
      byteWr = 1'b0;
    end
  endtask

  task automatic endFrame(logic v);
    frameEnd = 1'b1; frameValid = v; tick();
    frameEnd = 1'b0; frameValid = 1'b0;
  endtask

  task automatic drain();
    fifoEmpty = 1'b1; tick(); fifoEmpty = 1'b0;
  endtask

  function automatic int thrOf(int wm, logic fd, logic ra);
    int t;
    t = (wm == 0) ? 16 : (wm == 1) ? 64 : 128;
    if (!fd && !ra && t < 64) t = 64;
    return t;
  endfunction

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1: reset state
    chk("R1", dmaReq, 1'b0);
    chkNib("R1", cfgRdNibble, 4'b1101);

    // R2: write gating
    writeWm(2'b00, 1'b0, 1'b0); tick();
    chkNib("R2", cfgRdNibble, 4'b1101);
    writeWm(2'b00, 1'b0, 1'b1); tick();
    chkNib("R2", cfgRdNibble, 4'b1100);
    writeWm(2'b10, 1'b1, 1'b0); tick();
    chkNib("R2", cfgRdNibble, 4'b1110);

    // R3: stop alone keeps the field, soft reset restores it
    stopBit = 1'b1; repeat (3) tick(); stopBit = 1'b0;
    chkNib("R3", cfgRdNibble, 4'b1110);
    fullDuplex = 1'b1;
    startFrame(); sendBytes(130); tick();
    chk("R3", dmaReq, 1'b1);
    swReset = 1'b1; tick(); swReset = 1'b0;
    chkNib("R3", cfgRdNibble, 4'b1101);
    chk("R3", dmaReq, 1'b0);

    // R4/R5/R6 sweep over mode, watermark and count around threshold
    for (int fd = 0; fd < 2; fd++) begin
      for (int ra = 0; ra < 2; ra++) begin
        for (int wm = 0; wm < 4; wm++) begin
          writeWm(wm[1:0], 1'b1, 1'b0);
          fullDuplex = fd[0]; runtAccept = ra[0];
          for (int d = 0; d < 2; d++) begin
            int thr, n;
            string tag;
            thr = thrOf(wm, fd[0], ra[0]);
            n = thr - 1 + d;
            tag = fd[0] ? "R4" : (ra[0] ? "R6" : "R5");
            startFrame(); sendBytes(n); tick();
            chk(tag, dmaReq, (n >= thr));
            endFrame(1'b1);
            chk("R7", dmaReq, 1'b1);
            drain();
            chk("R10", dmaReq, 1'b0);
          end
        end
      end
    end

    // R4: exact timing of the rise
    writeWm(2'b00, 1'b1, 1'b0); fullDuplex = 1'b1; runtAccept = 1'b0;
    startFrame(); sendBytes(16);
    chk("R4", dmaReq, 1'b0);
    tick();
    chk("R4", dmaReq, 1'b1);
    endFrame(1'b1); drain();

    // R7: short valid frame in half duplex
    writeWm(2'b01, 1'b1, 1'b0); fullDuplex = 1'b0;
    startFrame(); sendBytes(5); tick();
    chk("R7", dmaReq, 1'b0);
    endFrame(1'b1);
    chk("R7", dmaReq, 1'b1);
    drain();

    // R8: invalid end below threshold
    startFrame(); sendBytes(10); tick(); endFrame(1'b0);
    chk("R8", dmaReq, 1'b0);
    tick();
    chk("R8", dmaReq, 1'b0);

    // R9: abort clears count and drops request
    startFrame(); sendBytes(40);
    frameAbort = 1'b1; tick(); frameAbort = 1'b0;
    chk("R9", dmaReq, 1'b0);
    startFrame(); sendBytes(30); tick();
    chk("R9", dmaReq, 1'b0);
    sendBytes(34); tick();
    chk("R9", dmaReq, 1'b1);
    frameAbort = 1'b1; tick(); frameAbort = 1'b0;
    chk("R9", dmaReq, 1'b0);

    // R10: early fifoEmpty ignored, hold until empty after end
    startFrame(); sendBytes(70); tick();
    fifoEmpty = 1'b1; tick(); fifoEmpty = 1'b0;
    chk("R10", dmaReq, 1'b1);
    endFrame(1'b1);
    chk("R10", dmaReq, 1'b1);
    repeat (3) tick();
    chk("R10", dmaReq, 1'b1);
    drain();
    chk("R10", dmaReq, 1'b0);

    // R11: long frame keeps the request past counter limit
    fullDuplex = 1'b1; writeWm(2'b00, 1'b1, 1'b0);
    startFrame(); sendBytes(300); tick();
    chk("R11", dmaReq, 1'b1);
    endFrame(1'b0);
    chk("R11", dmaReq, 1'b1);
    drain();
    chk("R11", dmaReq, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule